// File: doc/BRIEF.md
# Reseeded Chaotic Logistic-Map State Generator

This block produces a stream of 32-bit pseudo-random words. Each word is a fixed-point fraction in (0,1). Every enabled cycle applies the logistic map x -> 4x(1-x) to a state register. The full-width product is formed once, and the factor of four comes from taking the product two bit positions higher, so no second multiplier is needed. A start command loads a seed word into the state register. A seed of zero is never accepted as it stands.

A digitized logistic map falls into short cycles and fixed points. Two conditions break these. A step counter fires on every PERIOD-th step. A detector fires when the next value equals the current one or is zero. When either fires, the low five bits of the next value are replaced by the constant pattern 10010 before the value is stored, and the counter restarts. The block is meant to feed a later mixing stage. That stage samples `stateOut` whenever `valid` is high.

Top module: `lmap_reseed_gen`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `stateOut` is 0 and `valid` is 0.
- R2: When `start` is high at a clock edge, `stateOut` holds `seed` after that edge, the step counter restarts at zero and `valid` is 0. `start` takes priority over `enable`.
- R3: A start with `seed` equal to 0 loads 32'h0000_0012 instead: the pattern 10010 in bits [4:0], all other bits 0.
- R4: Suppose a step (`enable` high, `start` low) does not reseed. The new state is then bits [61:30] of the 64-bit product X*(2^32-X), where X is the unsigned state. For example 32'h2000_0000 steps to 32'h7000_0000, and 32'hFFFF_FFFF steps to 32'h0000_0003.
- R5: Count the steps since the last start or reseed. The step that brings this count to PERIOD (default 19) is a reseed. The new state keeps bits [31:5] of the map value and has bits [4:0] = 5'b10010.
- R6: If the map value equals the current state, the step is a reseed and the counter restarts. For example 32'hC000_0000 (0.75) steps to 32'hC000_0012.
- R7: If the map value is zero, the step is a reseed. For example 32'h8000_0000 steps to 32'h0000_0012.
- R8: A cycle with `enable` low and `start` low leaves `stateOut` unchanged, and `valid` is 0 in the following cycle.
- R9: `valid` is 1 in exactly the cycle after each step. In that cycle `stateOut` already shows the new state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load the seed and restart the step counter |
| enable | input | 1 | Advance the map by one step |
| seed | input | 32 | Seed fraction loaded on start |
| stateOut | output | 32 | Current state, i.e. the latest generated value |
| valid | output | 1 | High for one cycle after each step |

## Verification
Several seeds are chosen so that one step gives an exact, hand-checkable result. Eighths and sixteenths land on exact fractions and test the product slice (R4). The value 0.75 hits the non-zero fixed point, and 0.5 overflows to zero, so each detector branch is exercised separately. All-ones and one-LSB seeds test the slice at the bottom end of the range. Long runs from unrelated seeds are compared step by step with a bench model of the counter and the detector. These runs show whether a reseed lands on exactly the PERIOD-th step, and whether a fixed-point reseed restarts the count. Zero seeds and idle cycles complete the set.

// File: rtl/lmap_pkg.sv
package lmap_pkg;

  // Strobes from the sequencing logic to the state datapath.
  typedef struct packed {
    logic loadSeed;  // take the seed this cycle
    logic advance;   // apply one map step this cycle
    logic reseed;    // substitute the low-bit pattern into the stepped value
  } lmap_ctl_t;

endpackage

// File: rtl/lmap_datapath.sv
module lmap_datapath
  import lmap_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int PAT_BITS = 5,
  parameter int PATTERN  = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  lmap_ctl_t        ctl,
  input  logic [WIDTH-1:0] seed,
  output logic             fixedHit,
  output logic [WIDTH-1:0] state
);

  localparam int PROD_W = 2 * WIDTH;
  localparam int SLICE_HI = PROD_W - 3;   // product shifted left by 2, upper half
  localparam int SLICE_LO = WIDTH - 2;
  localparam logic [PAT_BITS-1:0] PAT = PAT_BITS'(PATTERN);

  logic [WIDTH-1:0]  stateQ;
  logic [WIDTH-1:0]  complement;
  logic [PROD_W-1:0] product;
  logic [WIDTH-1:0]  mapValue;
  logic [WIDTH-1:0]  perturbed;
  logic [WIDTH-1:0]  seedFixed;
  logic [WIDTH-1:0]  stepValue;

  // 1 - X as the two's complement of the fraction
  always_comb begin
    complement = (~stateQ) + WIDTH'(1);
    product    = {{WIDTH{1'b0}}, stateQ} * {{WIDTH{1'b0}}, complement};
    mapValue   = product[SLICE_HI:SLICE_LO];
  end

  assign fixedHit  = (mapValue == stateQ) || (mapValue == '0);
  assign perturbed = {mapValue[WIDTH-1:PAT_BITS], PAT};
  assign seedFixed = (seed == '0) ? {seed[WIDTH-1:PAT_BITS], PAT} : seed;
  assign stepValue = ctl.reseed ? perturbed : mapValue;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= '0;
    end else if (ctl.loadSeed) begin
      stateQ <= seedFixed;
    end else if (ctl.advance) begin
      stateQ <= stepValue;
    end
  end

  assign state = stateQ;

endmodule

// File: rtl/lmap_control.sv
module lmap_control
  import lmap_pkg::*;
#(
  parameter int PERIOD = 19,
  localparam int CNT_W = $clog2(PERIOD + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             enable,
  input  logic             fixedHit,
  output lmap_ctl_t        ctl,
  output logic [CNT_W-1:0] stepCount,
  output logic             valid
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] countQ;
  logic             validQ;
  logic             periodHit;

  assign periodHit    = (countQ == LAST);
  assign ctl.loadSeed = start;
  assign ctl.advance  = enable && !start;
  assign ctl.reseed   = ctl.advance && (periodHit || fixedHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= ctl.advance;
      if (ctl.loadSeed || ctl.reseed) begin
        countQ <= '0;
      end else if (ctl.advance) begin
        countQ <= countQ + CNT_W'(1);
      end
    end
  end

  assign stepCount = countQ;
  assign valid     = validQ;

endmodule

// File: rtl/lmap_reseed_gen.sv
module lmap_reseed_gen
  import lmap_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int PAT_BITS = 5,
  parameter int PATTERN  = 18,
  parameter int PERIOD   = 19
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             enable,
  input  logic [WIDTH-1:0] seed,
  output logic [WIDTH-1:0] stateOut,
  output logic             valid
);

  localparam int CNT_W = $clog2(PERIOD + 1);

  lmap_ctl_t        ctl;
  logic             fixedHit;
  logic [CNT_W-1:0] stepCount;

  lmap_control #(.PERIOD(PERIOD)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .enable   (enable),
    .fixedHit (fixedHit),
    .ctl      (ctl),
    .stepCount(stepCount),
    .valid    (valid)
  );

  lmap_datapath #(
    .WIDTH   (WIDTH),
    .PAT_BITS(PAT_BITS),
    .PATTERN (PATTERN)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .seed    (seed),
    .fixedHit(fixedHit),
    .state   (stateOut)
  );

endmodule

// File: rtl/lmap_reseed_chk.sv
module lmap_reseed_chk
  import lmap_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int PAT_BITS = 5,
  parameter int PATTERN  = 18,
  parameter int PERIOD   = 19,
  localparam int CNT_W   = $clog2(PERIOD + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             enable,
  input logic [WIDTH-1:0] seed,
  input logic [WIDTH-1:0] stateOut,
  input logic             valid,
  input lmap_ctl_t        ctl,
  input logic [CNT_W-1:0] stepCount
);

  localparam logic [PAT_BITS-1:0] PAT = PAT_BITS'(PATTERN);
  localparam logic [WIDTH-1:0] ZERO_SUB = WIDTH'(PATTERN);
  localparam logic [WIDTH-1:0] THREE_Q = {2'b11, {(WIDTH-2){1'b0}}};

  a_r2_seed_loaded: assert property (@(posedge clk) disable iff (!rstN)
    (start && seed != '0) |=> (stateOut == $past(seed) && !valid));

  a_r3_zero_seed_replaced: assert property (@(posedge clk) disable iff (!rstN)
    (start && seed == '0) |=> (stateOut == ZERO_SUB));

  a_r5_count_in_range: assert property (@(posedge clk) disable iff (!rstN)
    stepCount < CNT_W'(PERIOD));

  a_r5_pattern_after_reseed: assert property (@(posedge clk) disable iff (!rstN)
    ctl.reseed |=> (stateOut[PAT_BITS-1:0] == PAT && stepCount == '0));

  a_r6_three_quarter_escape: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !start && stateOut == THREE_Q) |=> (stateOut == {THREE_Q[WIDTH-1:PAT_BITS], PAT}));

  a_r7_never_zero_when_valid: assert property (@(posedge clk) disable iff (!rstN)
    valid |-> (stateOut != '0));

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !start) |=> ($stable(stateOut) && !valid));

  a_r9_valid_follows_step: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !start) |=> valid);

endmodule

bind lmap_reseed_gen lmap_reseed_chk #(
  .WIDTH   (WIDTH),
  .PAT_BITS(PAT_BITS),
  .PATTERN (PATTERN),
  .PERIOD  (PERIOD)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .enable   (enable),
  .seed     (seed),
  .stateOut (stateOut),
  .valid    (valid),
  .ctl      (ctl),
  .stepCount(stepCount)
);

// File: tb/sim_lmap_reseed_gen.sv
`timescale 1ns/1ps
module sim_lmap_reseed_gen;

  localparam int PERIOD = 19;
  localparam int NVEC = 9;
  // {seed, expected state after one step}
  localparam logic [63:0] VEC [NVEC] = '{
    {32'h2000_0000, 32'h7000_0000},  // R4 exact eighth
    {32'h1000_0000, 32'h3C00_0000},  // R4 sixteenth
    {32'h7000_0000, 32'hFC00_0000},  // R4
    {32'h4000_0000, 32'hC000_0000},  // R4 quarter -> three quarters
    {32'hFFFF_FFFF, 32'h0000_0003},  // R4 top end
    {32'h0000_0001, 32'h0000_0003},  // R4 bottom end
    {32'h0000_0003, 32'h0000_000B},  // R4
    {32'hC000_0000, 32'hC000_0012},  // R6 fixed point
    {32'h8000_0000, 32'h0000_0012}   // R7 overflow to zero
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        enable = 1'b0;
  logic [31:0] seed = '0;
  logic [31:0] stateOut;
  logic        valid;

  int tests = 0;
  int fails = 0;
  logic [31:0] mX;
  int          mCnt;

  always #2 clk = ~clk;

  lmap_reseed_gen u0 (
    .clk(clk), .rstN(rstN), .start(start), .enable(enable),
    .seed(seed), .stateOut(stateOut), .valid(valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mapOf(input logic [31:0] x);
    logic [63:0] p;
    p = {32'b0, x} * {32'b0, (~x) + 32'd1};
    return p[61:30];
  endfunction

  task automatic modelStart(input logic [31:0] s);
    mX = (s == 0) ? 32'h12 : s;
    mCnt = 0;
  endtask

  task automatic modelStep();
    logic [31:0] nx;
    nx = mapOf(mX);
    if (nx == mX || nx == 0 || mCnt == PERIOD - 1) begin
      mX = {nx[31:5], 5'b10010};
      mCnt = 0;
    end else begin
      mX = nx;
      mCnt++;
    end
  endtask

  task automatic doStart(input logic [31:0] s);
    seed = s; start = 1'b1; enable = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; enable = 1'b0;
    modelStart(s);
  endtask

  task automatic doStep();
    enable = 1'b1;
    @(posedge clk); #1;
    enable = 1'b0;
    modelStep();
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 state in reset", stateOut, 32'h0);
    check("R1 valid in reset", {31'b0, valid}, 32'h0);
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 state after reset", stateOut, 32'h0);

    // table walk: one step from each seed
    for (int i = 0; i < NVEC; i++) begin
      doStart(VEC[i][63:32]);
      check("R2 seed load", stateOut, VEC[i][63:32]);
      check("R2 valid low after start", {31'b0, valid}, 32'h0);
      doStep();
      check("R4/R6/R7 one step", stateOut, VEC[i][31:0]);
      check("R9 valid after step", {31'b0, valid}, 32'h1);
    end

    // zero seed
    doStart(32'h0);
    check("R3 zero seed", stateOut, 32'h0000_0012);

    // idle hold
    doStart(32'h2000_0000);
    doStep();
    repeat (3) @(posedge clk);
    #1;
    check("R8 hold on idle", stateOut, 32'h7000_0000);
    check("R8 valid low on idle", {31'b0, valid}, 32'h0);

    // period reseed: lands on the PERIOD-th step
    for (int s = 0; s < 3; s++) begin
      logic [31:0] sd;
      sd = (s == 0) ? 32'h1234_5678 : (s == 1) ? 32'h0BAD_F00D : 32'h5A5A_A5A5;
      doStart(sd);
      for (int k = 0; k < 3 * PERIOD + 5; k++) begin
        doStep();
        check("R5 long run vs model", stateOut, mX);
        if (k == PERIOD - 1 && mCnt == 0)
          check("R5 pattern on period step", {27'b0, stateOut[4:0]}, 32'h12);
      end
    end

    // fixed point reseed restarts the counter
    doStart(32'h4000_0000);
    doStep();
    doStep();
    check("R6 fixed point escape", stateOut, 32'hC000_0012);
    for (int k = 0; k < PERIOD + 2; k++) begin
      doStep();
      check("R6 counter restarted", stateOut, mX);
    end

    // start overrides enable in the same cycle
    seed = 32'h1000_0000; start = 1'b1; enable = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    check("R2 start priority", stateOut, 32'h1000_0000);
    @(posedge clk); #1;
    enable = 1'b0;
    check("R9 step after start", stateOut, 32'h3C00_0000);
    check("R9 valid with step", {31'b0, valid}, 32'h1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule